// File: doc/BRIEF.md
# Multi-mode configurable I/O port

This block controls a general-purpose port of eight pins. Every pin carries its own two-bit drive mode, an output latch bit and a synchronised read-back of the level actually present on the pad. From the mode and the latch, the block derives three pad controls per pin:

- a strong high drive,
- a strong low drive,
- a weak pull-up.

An external pad model resolves these controls, together with whatever else is connected to the pin, into the level that comes back on `pin_in`.

Software reaches the block through a simple register port. It has one write strobe with an address and data, and a separate read address whose data is returned combinationally. A pin-change interrupt unit watches the synchronised pin levels. Each pin is enabled separately and senses either a falling edge or a low level. The unit keeps one sticky flag per pin, and one request line is raised while any flag is set.

In quasi-bidirectional mode the pin acts like a classic microcontroller port bit. A write that raises a latch bit from 0 to 1 briefly turns on the strong high drive, so that the line rises quickly. The drive then falls back to the weak pull-up.

Top module: `multimode_port`

## Requirements
- R1: The register port decodes these addresses:
  - 0: output latch.
  - 1: low mode bits.
  - 2: high mode bits.
  - 3: pin level (read only; writes have no effect).
  - 4: interrupt enable.
  - 5: interrupt sense select.
  - 6: interrupt flags.
  - 7: reads zero.
  The mode of pin i is {high bit i, low bit i}, encoded as 00 = quasi-bidirectional, 01 = push-pull, 10 = input-only, 11 = open-drain.
- R2: A quasi-bidirectional pin drives strong low when its latch is 0 and enables the weak pull-up when its latch is 1. Outside a boost it never drives strong high.
- R3: The boost works as follows:
  - Trigger: a latch write that takes a bit of a quasi-bidirectional pin from 0 to 1.
  - Length: the strong high drive is on for exactly BOOST_CYCLES clock cycles (default 2), starting with the cycle after the write edge. It then drops back to the weak pull-up.
  - No trigger: writing 1 over a latch bit that is already 1 gives no boost.
- R4: A push-pull pin drives strong high when its latch is 1 and strong low when its latch is 0, with no weak pull-up.
- R5: An input-only pin enables none of the three pad controls, whatever its latch holds.
- R6: An open-drain pin drives strong low when its latch is 0. It never enables the strong high drive or the weak pull-up.
- R7: After reset:
  - every latch bit is 1 and every pin is quasi-bidirectional;
  - the interrupt enables, sense selects and flags are all 0;
  - the strong high drive is off on every pin.
- R8: Address 3 returns `pin_in` after a SYNC_STAGES-flop synchroniser (default 2). A level applied to the pin is readable no more than 3 cycles later.
- R9: Interrupt sensing is controlled per pin by the enable and the sense select:
  - Select bit 1: a falling edge of the synchronised pin sets the flag.
  - Select bit 0: a synchronised low level sets the flag.
  - Enable bit 0: the pin's flag never sets.
- R10: A flag bit is cleared by writing 0 to its position at address 6. Writing 1 leaves it unchanged. A set condition in the same cycle as the clear wins, so a level-sensed flag stays set while its pin is low.
- R11: `irq` is high exactly while at least one flag bit is set.
- R12: No pin ever has its strong high and strong low drives enabled at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | NPINS | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | NPINS | Register read data (combinational) |
| pin_in | input | NPINS | Resolved pad levels |
| drv_hi | output | NPINS | Per-pin strong high drive enable |
| drv_lo | output | NPINS | Per-pin strong low drive enable |
| pull_up | output | NPINS | Per-pin weak pull-up enable |
| irq | output | 1 | Pin-change interrupt request |

## Verification
The bound checker looks at every cycle for four things:
- no pin drives strong high and strong low together;
- no input-only pin has any control enabled, and no open-drain pin pulls high;
- no quasi-bidirectional pin holds its boost beyond BOOST_CYCLES;
- no flag rises on a disabled pin.

Other behaviour can only be shown by the bench's scenarios. These are the exact start and length of the boost, the per-mode levels for chosen latch patterns, and read-back through the synchroniser. They also cover edge sensing against level sensing on a pin held low, the write-zero clear losing to a persisting level, and the reset values.

// File: rtl/mmport_pkg.sv
package mmport_pkg;

   typedef enum logic [1:0] {
      PM_QUASI     = 2'b00,
      PM_PUSHPULL  = 2'b01,
      PM_INPUT     = 2'b10,
      PM_OPENDRAIN = 2'b11
   } pin_mode_t;

   localparam logic [2:0] RA_LATCH   = 3'd0;
   localparam logic [2:0] RA_MODE_LO = 3'd1;
   localparam logic [2:0] RA_MODE_HI = 3'd2;
   localparam logic [2:0] RA_PIN     = 3'd3;
   localparam logic [2:0] RA_IEN     = 3'd4;
   localparam logic [2:0] RA_ISEL    = 3'd5;
   localparam logic [2:0] RA_FLAG    = 3'd6;

endpackage

// File: rtl/mmport_sync.sv
module mmport_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '1;
      end else begin
         chain[0] <= din;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/mmport_pin_drive.sv
module mmport_pin_drive
   import mmport_pkg::*;
#(
   parameter int BOOST_CYCLES = 2
) (
   input  logic      clk,
   input  logic      rst_n,
   input  pin_mode_t mode,
   input  logic      latch_q,
   input  logic      latch_wr,
   input  logic      latch_wbit,
   output logic      drv_hi,
   output logic      drv_lo,
   output logic      pull_up
);
   localparam int CW = $clog2(BOOST_CYCLES + 1);

   logic [CW-1:0] boost_cnt;
   logic          boost_on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         boost_cnt <= '0;
      end else if (latch_wr && latch_wbit && !latch_q && mode == PM_QUASI) begin
         boost_cnt <= CW'(BOOST_CYCLES);
      end else if (latch_wr && !latch_wbit) begin
         boost_cnt <= '0;
      end else if (boost_on) begin
         boost_cnt <= boost_cnt - 1'b1;
      end
   end

   assign boost_on = (boost_cnt != '0);

   always_comb begin
      drv_hi  = 1'b0;
      drv_lo  = 1'b0;
      pull_up = 1'b0;
      unique case (mode)
         PM_QUASI: begin
            drv_lo  = ~latch_q;
            pull_up = latch_q;
            drv_hi  = latch_q & boost_on;
         end
         PM_PUSHPULL: begin
            drv_hi = latch_q;
            drv_lo = ~latch_q;
         end
         PM_OPENDRAIN: drv_lo = ~latch_q;
         default: ;
      endcase
   end
endmodule

// File: rtl/mmport_irq.sv
module mmport_irq #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] ien,
   input  logic [W-1:0] isel,
   input  logic         clr_wr,
   input  logic [W-1:0] clr_data,
   output logic [W-1:0] flags,
   output logic         irq
);
   logic [W-1:0] prev;
   logic [W-1:0] hit;

   assign hit = ien & ((isel & prev & ~lvl) | (~isel & ~lvl));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev  <= '1;
         flags <= '0;
      end else begin
         prev  <= lvl;
         flags <= (clr_wr ? (flags & clr_data) : flags) | hit;
      end
   end

   assign irq = |flags;
endmodule

// File: rtl/multimode_port.sv
module multimode_port
   import mmport_pkg::*;
#(
   parameter int NPINS        = 8,
   parameter int BOOST_CYCLES = 2,
   parameter int SYNC_STAGES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [NPINS-1:0] wr_data,
   input  logic [2:0]       rd_addr,
   output logic [NPINS-1:0] rd_data,
   input  logic [NPINS-1:0] pin_in,
   output logic [NPINS-1:0] drv_hi,
   output logic [NPINS-1:0] drv_lo,
   output logic [NPINS-1:0] pull_up,
   output logic             irq
);
   if (NPINS < 1 || NPINS > 32) begin : g_bad_npins
      $error("multimode_port: NPINS must lie in 1..32");
   end
   if (BOOST_CYCLES < 1 || BOOST_CYCLES > 64) begin : g_bad_boost
      $error("multimode_port: BOOST_CYCLES must lie in 1..64");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("multimode_port: SYNC_STAGES must be at least 2");
   end

   logic [NPINS-1:0] latch_q, mode_lo_q, mode_hi_q, ien_q, isel_q;
   logic [NPINS-1:0] pin_sync, flags;
   logic             wr_latch, wr_flag;

   assign wr_latch = wr_en && (wr_addr == RA_LATCH);
   assign wr_flag  = wr_en && (wr_addr == RA_FLAG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q   <= '1;
         mode_lo_q <= '0;
         mode_hi_q <= '0;
         ien_q     <= '0;
         isel_q    <= '0;
      end else if (wr_en) begin
         unique case (wr_addr)
            RA_LATCH:   latch_q   <= wr_data;
            RA_MODE_LO: mode_lo_q <= wr_data;
            RA_MODE_HI: mode_hi_q <= wr_data;
            RA_IEN:     ien_q     <= wr_data;
            RA_ISEL:    isel_q    <= wr_data;
            default: ;
         endcase
      end
   end

   mmport_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (pin_in),
      .dout (pin_sync)
   );

   mmport_irq #(.W(NPINS)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl     (pin_sync),
      .ien     (ien_q),
      .isel    (isel_q),
      .clr_wr  (wr_flag),
      .clr_data(wr_data),
      .flags   (flags),
      .irq     (irq)
   );

   for (genvar i = 0; i < NPINS; i++) begin : g_pin
      mmport_pin_drive #(.BOOST_CYCLES(BOOST_CYCLES)) u_drv (
         .clk       (clk),
         .rst_n     (rst_n),
         .mode      (pin_mode_t'({mode_hi_q[i], mode_lo_q[i]})),
         .latch_q   (latch_q[i]),
         .latch_wr  (wr_latch),
         .latch_wbit(wr_data[i]),
         .drv_hi    (drv_hi[i]),
         .drv_lo    (drv_lo[i]),
         .pull_up   (pull_up[i])
      );
   end

   always_comb begin
      unique case (rd_addr)
         RA_LATCH:   rd_data = latch_q;
         RA_MODE_LO: rd_data = mode_lo_q;
         RA_MODE_HI: rd_data = mode_hi_q;
         RA_PIN:     rd_data = pin_sync;
         RA_IEN:     rd_data = ien_q;
         RA_ISEL:    rd_data = isel_q;
         RA_FLAG:    rd_data = flags;
         default:    rd_data = '0;
      endcase
   end
endmodule

// File: rtl/mmport_chk.sv
module mmport_chk #(
   parameter int NPINS        = 8,
   parameter int BOOST_CYCLES = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NPINS-1:0] mode_lo_q,
   input logic [NPINS-1:0] mode_hi_q,
   input logic [NPINS-1:0] drv_hi,
   input logic [NPINS-1:0] drv_lo,
   input logic [NPINS-1:0] pull_up,
   input logic [NPINS-1:0] flags,
   input logic [NPINS-1:0] ien_q
);
   localparam int RW = $clog2(BOOST_CYCLES + 2);

   logic [NPINS-1:0] quasi_m, input_m, od_m;
   assign quasi_m = ~mode_hi_q & ~mode_lo_q;
   assign input_m =  mode_hi_q & ~mode_lo_q;
   assign od_m    =  mode_hi_q &  mode_lo_q;

   assert_no_contention_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_hi & drv_lo) == '0);

   assert_input_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ((drv_hi | drv_lo | pull_up) & input_m) == '0);

   assert_od_never_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((drv_hi | pull_up) & od_m) == '0);

   assert_disabled_no_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (flags & ~$past(flags) & ~$past(ien_q)) == '0);

   for (genvar i = 0; i < NPINS; i++) begin : g_run
      logic [RW-1:0] run;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   run <= '0;
         else if (!(drv_hi[i] && quasi_m[i]))          run <= '0;
         else if (run <= RW'(BOOST_CYCLES))            run <= run + 1'b1;
      end
      assert_boost_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
         run <= RW'(BOOST_CYCLES));
   end
endmodule

bind multimode_port mmport_chk #(.NPINS(NPINS), .BOOST_CYCLES(BOOST_CYCLES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode_lo_q(mode_lo_q),
   .mode_hi_q(mode_hi_q),
   .drv_hi   (drv_hi),
   .drv_lo   (drv_lo),
   .pull_up  (pull_up),
   .flags    (flags),
   .ien_q    (ien_q)
);

// File: tb/tb_multimode_port.sv
module tb_multimode_port;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   localparam int K_RD = 0, K_HI = 1, K_LO = 2, K_PU = 3, K_IRQ = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data, pin_in, drv_hi, drv_lo, pull_up;
   logic       irq;
   logic [7:0] ext_en = '0, ext_val = '0;

   int  vectors = 0, miscompares = 0;
   bit  done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   multimode_port dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .pin_in(pin_in), .drv_hi(drv_hi),
      .drv_lo(drv_lo), .pull_up(pull_up), .irq(irq)
   );

   // pad model: strong drive wins, then an external driver, then pull-up; a floating pin reads 1
   always_comb begin
      for (int i = 0; i < 8; i++) begin
         if (drv_lo[i])       pin_in[i] = 1'b0;
         else if (drv_hi[i])  pin_in[i] = 1'b1;
         else if (ext_en[i])  pin_in[i] = ext_val[i];
         else                 pin_in[i] = 1'b1;
      end
   end

   typedef struct {
      int         kind;
      logic [7:0] exp;
      string      req;
   } item_t;
   item_t sb_q[$];

   // monitor: pops every pending item and compares it with the observed output
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         item_t it;
         logic [7:0] got;
         it = sb_q.pop_front();
         case (it.kind)
            K_RD:    got = rd_data;
            K_HI:    got = drv_hi;
            K_LO:    got = drv_lo;
            K_PU:    got = pull_up;
            default: got = {7'b0, irq};
         endcase
         vectors++;
         if (got !== it.exp) begin
            miscompares++;
            $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, got, it.exp);
         end
      end
   end

   task automatic expect_val(int kind, logic [7:0] exp, string req);
      sb_q.push_back('{kind, exp, req});
      @(negedge clk);
      #1;
   endtask

   task automatic read_chk(logic [2:0] a, logic [7:0] exp, string req);
      rd_addr = a;
      expect_val(K_RD, exp, req);
   endtask

   task automatic wr(logic [2:0] a, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // steady-state pad controls from the mode rules (R2, R4, R5, R6), boost excluded
   function automatic logic [23:0] model(logic [7:0] lo, logic [7:0] hi, logic [7:0] lat);
      logic [7:0] h = '0, l = '0, p = '0;
      for (int i = 0; i < 8; i++) begin
         case ({hi[i], lo[i]})
            2'b00: begin l[i] = ~lat[i]; p[i] = lat[i]; end
            2'b01: begin h[i] = lat[i];  l[i] = ~lat[i]; end
            2'b11: l[i] = ~lat[i];
            default: ;
         endcase
      end
      return {h, l, p};
   endfunction

   task automatic mode_chk(logic [7:0] lo, logic [7:0] hi, logic [7:0] lat, string req);
      logic [23:0] m;
      wr(3'd1, lo);
      wr(3'd2, hi);
      wr(3'd0, lat);
      idle(3);
      m = model(lo, hi, lat);
      expect_val(K_HI, m[23:16], req);
      expect_val(K_LO, m[15:8], req);
      expect_val(K_PU, m[7:0], req);
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      idle(3);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R7 reset state
      read_chk(3'd0, 8'hFF, "R7 latch reset");
      read_chk(3'd1, 8'h00, "R7 mode lo reset");
      read_chk(3'd2, 8'h00, "R7 mode hi reset");
      read_chk(3'd4, 8'h00, "R7 enable reset");
      read_chk(3'd6, 8'h00, "R7 flag reset");
      expect_val(K_HI, 8'h00, "R7 no high drive");
      expect_val(K_PU, 8'hFF, "R7 pull-ups");
      read_chk(3'd7, 8'h00, "R1 unused address");

      // R2 quasi with mixed latch, no rising bits
      wr(3'd0, 8'h0F);
      expect_val(K_HI, 8'h00, "R2 quasi no boost");
      expect_val(K_LO, 8'hF0, "R2 quasi low drive");
      expect_val(K_PU, 8'h0F, "R2 quasi pull-up");

      // R3 boost: bits 7:4 rise
      wr(3'd0, 8'hFF);
      expect_val(K_HI, 8'hF0, "R3 boost cycle 1");
      expect_val(K_HI, 8'hF0, "R3 boost cycle 2");
      expect_val(K_HI, 8'h00, "R3 boost ended");
      expect_val(K_PU, 8'hFF, "R3 weak pull-up after boost");
      // R3 rewrite of ones gives no boost
      wr(3'd0, 8'hFF);
      expect_val(K_HI, 8'h00, "R3 no boost on 1->1");

      mode_chk(8'hFF, 8'h00, 8'hA5, "R4 push-pull");
      mode_chk(8'h00, 8'hFF, 8'hA5, "R5 input-only");
      mode_chk(8'hFF, 8'hFF, 8'hA5, "R6 open-drain");
      mode_chk(8'hFF, 8'hFF, 8'hFF, "R6 open-drain latch ones");
      mode_chk(8'h0C, 8'h0A, 8'h00, "R1 mixed modes latch 0");
      mode_chk(8'h0C, 8'h0A, 8'h5F, "R1 mixed modes latch 5F");
      read_chk(3'd1, 8'h0C, "R1 mode lo readback");
      read_chk(3'd2, 8'h0A, "R1 mode hi readback");

      // R8 pin read in input-only mode
      wr(3'd1, 8'h00);
      wr(3'd2, 8'hFF);
      ext_en = 8'hFF; ext_val = 8'h3C;
      idle(3);
      read_chk(3'd3, 8'h3C, "R8 pin read");
      wr(3'd3, 8'h00);
      read_chk(3'd3, 8'h3C, "R1 pin address write ignored");
      ext_en = 8'h00;

      // back to quasi, latch ones, for interrupt tests
      wr(3'd2, 8'h00);
      wr(3'd0, 8'hFF);
      idle(4);
      read_chk(3'd6, 8'h00, "R9 no flags yet");

      // R9 edge on pin 2, level on pin 5, pin 6 disabled
      wr(3'd5, 8'h04);
      wr(3'd4, 8'h24);
      ext_en = 8'h44; ext_val = 8'h00;
      idle(4);
      read_chk(3'd6, 8'h04, "R9 edge flag only, pin 6 disabled");
      expect_val(K_IRQ, 8'h01, "R11 irq set");
      wr(3'd6, 8'hFB);
      read_chk(3'd6, 8'h00, "R10 edge flag cleared by 0");
      expect_val(K_IRQ, 8'h00, "R11 irq clear");

      // R9 level on pin 5
      ext_en = 8'h64; ext_val = 8'h00;
      idle(4);
      read_chk(3'd6, 8'h20, "R9 level flag");
      wr(3'd6, 8'h00);
      read_chk(3'd6, 8'h20, "R10 level wins over clear");
      ext_en = 8'h04;
      idle(4);
      wr(3'd6, 8'hDF);
      read_chk(3'd6, 8'h00, "R10 clear after release");
      wr(3'd6, 8'hFF);
      read_chk(3'd6, 8'h00, "R10 writing ones no effect");
      expect_val(K_IRQ, 8'h00, "R11 irq idle");
      ext_en = 8'h00;
      idle(4);
      read_chk(3'd6, 8'h00, "R9 rising edge no flag");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule